// File: doc/BRIEF.md
# Start-up and Interrupt Vector Sequencer

This block decides when a processor core may run and where it fetches from. An external reset request, active high, is first passed through a synchronizer. The request counts only if it stays high for at least five sampled clock cycles. While the request is high the core is held dormant. When a valid request falls, a fixed internal start-up delay runs. The core is then released, with a one-cycle pulse that carries the first fetch address FFFF0h.

Right after each start-up, recognition of the non-maskable interrupt is held off for two running cycles. For a maskable interrupt, the acknowledge strobe captures the 8-bit type number from the interrupting device. The block then returns the address of that type's 4-byte pointer in the table at the bottom of memory.

A request that is too short is discarded. When the core was already running, it only pauses and then resumes without a new start-up. When the core was still waiting for its first start, it keeps waiting.

Top module: `boot_irq_seq`

## Requirements
- R1: While `rst_n` is low, and afterwards until a valid request completes its start-up, `core_run_o`, `fetch_vld_o`, `nmi_en_o`, `nmi_take_o` and `vec_vld_o` are all 0.
- R2: A `rst_req_i` pulse sampled high on fewer than 5 rising edges is discarded: it starts no start-up sequence and produces no fetch pulse.
- R3: `core_run_o` falls 3 cycles after `rst_req_i` rises (2 synchronizer stages plus 1) and stays low while the request is held high.
- R4: After a valid request falls, `core_run_o` rises exactly 10 cycles later (2 synchronizer stages, 1 detection cycle, 7 delay cycles). `fetch_vld_o` is high for exactly that first running cycle, with `fetch_addr_o` = 20'hFFFF0.
- R5: A discarded short request while the core runs pauses it. The core resumes 3 cycles after the request falls, with no fetch pulse and with `nmi_en_o` as it was before the pause.
- R6: `nmi_en_o` is low in the first two running cycles after a start-up and high from the third. It is never high while `core_run_o` is low.
- R7: `nmi_take_o` pulses for one cycle after a rising edge of `nmi_i` is sampled while `nmi_en_o` is high. A rising edge sampled while `nmi_en_o` is low is ignored, even if `nmi_i` then stays high.
- R8: An `ack_i` cycle while running sets `vec_vld_o` for exactly the next cycle. `vec_addr_o` then equals type times 4: bits [9:2] hold `type_i`, bits [1:0] and [19:10] are zero.
- R9: An `ack_i` cycle while the core is not running is ignored: `vec_vld_o` stays low.
- R10: A valid request while the core runs restarts the whole sequence, including the NMI hold-off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous active-low block reset, released synchronously |
| rst_req_i | input | 1 | External reset request, active high, asynchronous |
| nmi_i | input | 1 | Non-maskable interrupt request, synchronous |
| ack_i | input | 1 | Interrupt-acknowledge cycle strobe |
| type_i | input | 8 | Interrupt type number supplied during acknowledge |
| core_run_o | output | 1 | Core may execute |
| fetch_vld_o | output | 1 | One-cycle pulse marking the first fetch after start-up |
| fetch_addr_o | output | 20 | First fetch address |
| nmi_en_o | output | 1 | NMI recognition open |
| nmi_take_o | output | 1 | One-cycle pulse: NMI recognized |
| vec_vld_o | output | 1 | Vector address valid for one cycle |
| vec_addr_o | output | 20 | Vector-table entry address |

## Verification
Several relations are checked on every cycle:
- `fetch_vld_o` is a single-cycle pulse inside running time.
- `nmi_en_o` only appears while the core runs and stays low on the start-up cycle and the one after it.
- Every accepted NMI follows an enabled rising edge.
- Vector output appears only after an acknowledge taken while running, and always carries the captured type in the right field.

The exact latency counts from request edges to `core_run_o` depend on multi-cycle histories, so the bench's scenarios show them. The same holds for discarding pulses of four samples against accepting five, resuming without a fetch pulse, and re-arming the NMI hold-off after a restart.

// File: rtl/boot_irq_pkg.sv
package boot_irq_pkg;
  // Defaults shared by the sequencer and its checker
  localparam int ADDR_W_D      = 20;
  localparam int TYPE_W_D      = 8;
  localparam int ENTRY_BYTES_D = 4;
  localparam int SYNC_STG_D    = 2;
  localparam int MIN_HIGH_D    = 5;
  localparam int START_DLY_D   = 7;
  localparam int NMI_HOLD_D    = 2;
  localparam logic [19:0] BOOT_ADDR_D = 20'hFFFF0;

  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,  // never started, dormant
    ST_RUN  = 2'd1,  // core executing
    ST_HIGH = 2'd2,  // request seen high, width being measured
    ST_SEQ  = 2'd3   // post-request start-up delay
  } seq_state_e;
endpackage

// File: rtl/bis_sync.sv
module bis_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sh_d = d_i;
    end else begin : g_chain
      always_comb sh_d = {sh_q[STAGES-2:0], d_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/bis_start_fsm.sv
module bis_start_fsm
  import boot_irq_pkg::*;
#(
  parameter int MIN_HIGH  = MIN_HIGH_D,
  parameter int START_DLY = START_DLY_D
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_s_i,   // synchronized reset request
  output logic run_o,
  output logic boot_o,    // dormant or sequencing: NMI hold-off is cleared
  output logic start_o    // first running cycle after a start-up
);
  localparam int WCW = $clog2(MIN_HIGH + 1);
  localparam int DCW = (START_DLY > 1) ? $clog2(START_DLY) : 1;
  localparam logic [WCW-1:0] W_MIN  = WCW'(MIN_HIGH);
  localparam logic [DCW-1:0] D_LAST = DCW'(START_DLY - 1);

  seq_state_e     state_q, state_d;
  logic [WCW-1:0] wcnt_q, wcnt_d;
  logic [DCW-1:0] dcnt_q, dcnt_d;
  logic           ok_q, ok_d;      // core has a completed start-up to resume
  logic           start_q, start_d;

  always_comb begin
    state_d = state_q;
    wcnt_d  = wcnt_q;
    dcnt_d  = dcnt_q;
    ok_d    = ok_q;
    start_d = 1'b0;
    case (state_q)
      ST_OFF, ST_RUN: begin
        if (req_s_i) begin
          state_d = ST_HIGH;
          wcnt_d  = WCW'(1);
        end
      end
      ST_HIGH: begin
        if (req_s_i) begin
          if (wcnt_q != W_MIN) wcnt_d = wcnt_q + WCW'(1);
        end else if (wcnt_q == W_MIN) begin
          state_d = ST_SEQ;
          dcnt_d  = '0;
          ok_d    = 1'b0;
        end else begin
          state_d = ok_q ? ST_RUN : ST_OFF;
        end
      end
      ST_SEQ: begin
        if (req_s_i) begin
          state_d = ST_HIGH;
          wcnt_d  = WCW'(1);
        end else if (dcnt_q == D_LAST) begin
          state_d = ST_RUN;
          ok_d    = 1'b1;
          start_d = 1'b1;
        end else begin
          dcnt_d = dcnt_q + DCW'(1);
        end
      end
      default: state_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OFF;
      wcnt_q  <= '0;
      dcnt_q  <= '0;
      ok_q    <= 1'b0;
      start_q <= 1'b0;
    end else begin
      state_q <= state_d;
      wcnt_q  <= wcnt_d;
      dcnt_q  <= dcnt_d;
      ok_q    <= ok_d;
      start_q <= start_d;
    end
  end

  assign run_o   = (state_q == ST_RUN);
  assign boot_o  = (state_q == ST_OFF) || (state_q == ST_SEQ);
  assign start_o = start_q;
endmodule

// File: rtl/bis_nmi_gate.sv
module bis_nmi_gate #(
  parameter int HOLD = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic boot_i,
  input  logic nmi_i,
  output logic en_o,
  output logic take_o
);
  localparam int BCW = $clog2(HOLD + 1);
  localparam logic [BCW-1:0] B_HOLD = BCW'(HOLD);

  logic [BCW-1:0] bcnt_q, bcnt_d;
  logic           prev_q;
  logic           take_q, take_d;
  logic           en;

  assign en = run_i && (bcnt_q == B_HOLD);

  always_comb begin
    bcnt_d = bcnt_q;
    if (boot_i)                          bcnt_d = '0;
    else if (run_i && bcnt_q != B_HOLD)  bcnt_d = bcnt_q + BCW'(1);
    take_d = en && nmi_i && !prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcnt_q <= '0;
      prev_q <= 1'b0;
      take_q <= 1'b0;
    end else begin
      bcnt_q <= bcnt_d;
      prev_q <= nmi_i;
      take_q <= take_d;
    end
  end

  assign en_o   = en;
  assign take_o = take_q;
endmodule

// File: rtl/bis_vector.sv
module bis_vector #(
  parameter int ADDR_W      = 20,
  parameter int TYPE_W      = 8,
  parameter int ENTRY_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              ack_i,
  input  logic [TYPE_W-1:0] type_i,
  output logic              vld_o,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int SHIFT = $clog2(ENTRY_BYTES);

  logic              cap;
  logic              vld_q;
  logic [ADDR_W-1:0] addr_q, addr_d;

  assign cap = en_i && ack_i;

  always_comb begin
    addr_d = '0;
    addr_d[TYPE_W+SHIFT-1:SHIFT] = type_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      addr_q <= '0;
    end else begin
      vld_q <= cap;
      if (cap) addr_q <= addr_d;
    end
  end

  assign vld_o  = vld_q;
  assign addr_o = addr_q;
endmodule

// File: rtl/boot_irq_seq.sv
module boot_irq_seq
  import boot_irq_pkg::*;
#(
  parameter int          ADDR_W      = ADDR_W_D,
  parameter int          TYPE_W      = TYPE_W_D,
  parameter int          ENTRY_BYTES = ENTRY_BYTES_D,
  parameter int          SYNC_STG    = SYNC_STG_D,
  parameter int          MIN_HIGH    = MIN_HIGH_D,
  parameter int          START_DLY   = START_DLY_D,
  parameter int          NMI_HOLD    = NMI_HOLD_D,
  parameter logic [19:0] BOOT_ADDR   = BOOT_ADDR_D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rst_req_i,
  input  logic              nmi_i,
  input  logic              ack_i,
  input  logic [TYPE_W-1:0] type_i,
  output logic              core_run_o,
  output logic              fetch_vld_o,
  output logic [ADDR_W-1:0] fetch_addr_o,
  output logic              nmi_en_o,
  output logic              nmi_take_o,
  output logic              vec_vld_o,
  output logic [ADDR_W-1:0] vec_addr_o
);
  logic req_s;
  logic run;
  logic boot;
  logic start;

  bis_sync #(.STAGES(SYNC_STG)) sync_i (
    .clk(clk), .rst_n(rst_n), .d_i(rst_req_i), .q_o(req_s)
  );

  bis_start_fsm #(.MIN_HIGH(MIN_HIGH), .START_DLY(START_DLY)) fsm_i (
    .clk(clk), .rst_n(rst_n), .req_s_i(req_s),
    .run_o(run), .boot_o(boot), .start_o(start)
  );

  bis_nmi_gate #(.HOLD(NMI_HOLD)) nmi_i0 (
    .clk(clk), .rst_n(rst_n), .run_i(run), .boot_i(boot),
    .nmi_i(nmi_i), .en_o(nmi_en_o), .take_o(nmi_take_o)
  );

  bis_vector #(.ADDR_W(ADDR_W), .TYPE_W(TYPE_W), .ENTRY_BYTES(ENTRY_BYTES)) vec_i (
    .clk(clk), .rst_n(rst_n), .en_i(run), .ack_i(ack_i), .type_i(type_i),
    .vld_o(vec_vld_o), .addr_o(vec_addr_o)
  );

  assign core_run_o   = run;
  assign fetch_vld_o  = start;
  assign fetch_addr_o = ADDR_W'(BOOT_ADDR);
endmodule

// File: rtl/boot_irq_seq_chk.sv
module boot_irq_seq_chk #(
  parameter int ADDR_W = 20,
  parameter int TYPE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              nmi_i,
  input logic              ack_i,
  input logic [TYPE_W-1:0] type_i,
  input logic              core_run_o,
  input logic              fetch_vld_o,
  input logic              nmi_en_o,
  input logic              nmi_take_o,
  input logic              vec_vld_o,
  input logic [ADDR_W-1:0] vec_addr_o
);
  // R4
  fetch_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_vld_o |-> core_run_o);
  // R4
  fetch_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_vld_o |=> !fetch_vld_o);
  // R6
  nmi_en_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_en_o |-> core_run_o);
  // R6
  nmi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_vld_o |-> !nmi_en_o ##1 !nmi_en_o);
  // R7
  nmi_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_take_o |-> ($past(nmi_en_o) && $past(nmi_i) && !$past(nmi_i, 2)));
  // R8
  vec_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && core_run_o) |=> (vec_vld_o && vec_addr_o[TYPE_W+1:2] == $past(type_i)));
  // R8
  vec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_vld_o |-> (vec_addr_o[1:0] == 2'b00 && vec_addr_o[ADDR_W-1:TYPE_W+2] == '0));
  // R9
  vec_dormant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !core_run_o |=> !vec_vld_o);
endmodule

bind boot_irq_seq boot_irq_seq_chk #(.ADDR_W(ADDR_W), .TYPE_W(TYPE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .nmi_i(nmi_i), .ack_i(ack_i), .type_i(type_i),
  .core_run_o(core_run_o), .fetch_vld_o(fetch_vld_o), .nmi_en_o(nmi_en_o),
  .nmi_take_o(nmi_take_o), .vec_vld_o(vec_vld_o), .vec_addr_o(vec_addr_o)
);

// File: tb/boot_irq_seq_tb_top.sv
`timescale 1ns/1ps
module boot_irq_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n, rst_req_i, nmi_i, ack_i;
  logic [7:0]  type_i;
  logic        core_run_o, fetch_vld_o, nmi_en_o, nmi_take_o, vec_vld_o;
  logic [19:0] fetch_addr_o, vec_addr_o;

  int checks = 0;
  int fails  = 0;
  int fetch_cnt = 0;
  int take_cnt  = 0;

  always #2 clk = ~clk;

  boot_irq_seq dut_i (
    .clk(clk), .rst_n(rst_n), .rst_req_i(rst_req_i), .nmi_i(nmi_i),
    .ack_i(ack_i), .type_i(type_i), .core_run_o(core_run_o),
    .fetch_vld_o(fetch_vld_o), .fetch_addr_o(fetch_addr_o),
    .nmi_en_o(nmi_en_o), .nmi_take_o(nmi_take_o),
    .vec_vld_o(vec_vld_o), .vec_addr_o(vec_addr_o)
  );

  always @(negedge clk) begin
    if (fetch_vld_o) fetch_cnt++;
    if (nmi_take_o)  take_cnt++;
  end

  // {type, expected entry address}
  localparam logic [27:0] VEC_TAB [8] = '{
    {8'h00, 20'h00000}, {8'h01, 20'h00004}, {8'h7F, 20'h001FC},
    {8'h80, 20'h00200}, {8'hFF, 20'h003FC}, {8'h3C, 20'h000F0},
    {8'h02, 20'h00008}, {8'hA5, 20'h00294}
  };

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_run(output int n);
    n = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      n++;
      if (core_run_o) break;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n;
    int f0;
    rst_n = 1'b0; rst_req_i = 1'b0; nmi_i = 1'b0; ack_i = 1'b0; type_i = '0;
    repeat (3) @(negedge clk);
    chk(core_run_o == 0 && fetch_vld_o == 0, "R1 run/fetch in reset", core_run_o, 0);
    chk(nmi_en_o == 0 && nmi_take_o == 0 && vec_vld_o == 0, "R1 nmi/vec in reset", nmi_en_o, 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(core_run_o == 0, "R1 dormant before first request", core_run_o, 0);

    // R2: four-sample pulse from dormant is discarded
    rst_req_i = 1'b1; repeat (4) @(negedge clk); rst_req_i = 1'b0;
    repeat (20) @(negedge clk);
    chk(core_run_o == 0, "R2 short pulse no start", core_run_o, 0);
    chk(fetch_cnt == 0, "R2 short pulse no fetch", fetch_cnt, 0);

    // R4: five-sample pulse is valid
    rst_req_i = 1'b1; repeat (5) @(negedge clk); rst_req_i = 1'b0;
    wait_run(n);
    chk(n == 10, "R4 start latency", n, 10);
    chk(fetch_vld_o == 1, "R4 fetch pulse", fetch_vld_o, 1);
    chk(fetch_addr_o == 20'hFFFF0, "R4 fetch address", fetch_addr_o, 20'hFFFF0);
    chk(nmi_en_o == 0, "R6 hold-off cycle 0", nmi_en_o, 0);
    nmi_i = 1'b1;                    // R7: edge inside the hold-off
    @(negedge clk);
    chk(fetch_vld_o == 0, "R4 fetch single cycle", fetch_vld_o, 0);
    chk(nmi_en_o == 0, "R6 hold-off cycle 1", nmi_en_o, 0);
    @(negedge clk);
    chk(nmi_en_o == 1, "R6 enabled cycle 2", nmi_en_o, 1);
    repeat (2) @(negedge clk);
    nmi_i = 1'b0;
    @(negedge clk);
    chk(take_cnt == 0, "R7 edge in hold-off ignored", take_cnt, 0);
    nmi_i = 1'b1;
    @(negedge clk);
    chk(nmi_take_o == 1, "R7 nmi taken", nmi_take_o, 1);
    @(negedge clk);
    chk(nmi_take_o == 0, "R7 take single cycle", nmi_take_o, 0);
    nmi_i = 1'b0;
    repeat (2) @(negedge clk);
    chk(take_cnt == 1, "R7 one take per edge", take_cnt, 1);

    // R8: vector table walk
    for (int i = 0; i < 8; i++) begin
      ack_i = 1'b1; type_i = VEC_TAB[i][27:20];
      @(negedge clk);
      ack_i = 1'b0;
      chk(vec_vld_o == 1, "R8 vector valid", vec_vld_o, 1);
      chk(vec_addr_o == VEC_TAB[i][19:0], "R8 vector address", vec_addr_o, VEC_TAB[i][19:0]);
      @(negedge clk);
      chk(vec_vld_o == 0, "R8 vector valid single cycle", vec_vld_o, 0);
    end

    // R3/R5: short pulse while running pauses and resumes
    f0 = fetch_cnt;
    rst_req_i = 1'b1;
    repeat (2) @(negedge clk);
    chk(core_run_o == 1, "R3 still running at cycle 2", core_run_o, 1);
    @(negedge clk);
    chk(core_run_o == 0, "R3 stopped at cycle 3", core_run_o, 0);
    rst_req_i = 1'b0;
    wait_run(n);
    chk(n == 3, "R5 resume latency", n, 3);
    chk(fetch_cnt == f0, "R5 no fetch on resume", fetch_cnt, f0);
    chk(nmi_en_o == 1, "R5 nmi enable kept", nmi_en_o, 1);

    // R9/R10: valid request while running, acknowledge while dormant
    rst_req_i = 1'b1;
    repeat (4) @(negedge clk);
    ack_i = 1'b1; type_i = 8'h55;
    @(negedge clk);
    ack_i = 1'b0;
    chk(vec_vld_o == 0, "R9 ack ignored while dormant", vec_vld_o, 0);
    repeat (4) @(negedge clk);
    chk(core_run_o == 0, "R3 dormant while held", core_run_o, 0);
    chk(vec_vld_o == 0, "R9 no late vector", vec_vld_o, 0);
    rst_req_i = 1'b0;
    wait_run(n);
    chk(n == 10, "R10 restart latency", n, 10);
    chk(fetch_vld_o == 1, "R10 fetch after restart", fetch_vld_o, 1);
    chk(nmi_en_o == 0, "R10 hold-off rearmed", nmi_en_o, 0);
    repeat (2) @(negedge clk);
    chk(nmi_en_o == 1, "R10 enabled after hold-off", nmi_en_o, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule